// File: doc/BRIEF.md
# Polled TDMA Slot Controller

This block decides when a station on a shared half-duplex radio channel may key its transmitter. The network is a star: one hub and a small set of remote users. The hub opens every cycle with a query frame, and that query is the common time reference for the whole network. After the query, the channel is divided into back-to-back user slots of fixed length. Each user may speak only in its own slot, and only if it had data waiting when the query arrived.

All timing is counted in ticks of a slow enable input, so the same logic serves any slot duration. In hub mode the block raises a one-clock request at the start of each cycle. It keys the radio for the query phase, repeats the cycle at a fixed interval and then walks through the user slots. In user mode the sweep is anchored to a query-detected pulse from the receiver. The push-to-talk line covers the whole of the station's own slot. The data window opens a guard time after the line is keyed and closes a guard time before it is released. A watchdog abandons the sweep if no query has been seen for too long.

Top module: `tdma_slot_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no query seen, tx_enable, ptt, query_req and slot_active are low and slot_idx is 0.
- R2: In user mode, a clock with query_det high starts a sweep: slot_active is high and slot_idx is 0 after that clock. Tick position p (ticks counted after the query clock) lies in slot p / SLOT_TICKS. slot_active falls once N_USERS*SLOT_TICKS ticks have been counted. A tick in the same clock as query_det is not counted.
- R3: In user mode, ptt is high for every position of the slot whose index equals user_id, if data_pending was high in the query clock. Later changes of data_pending have no effect. A user_id of N_USERS or more never keys.
- R4: In user mode, tx_enable is high only in the user's keyed slot, at in-slot positions GUARD_TICKS through SLOT_TICKS-GUARD_TICKS-1. This places the window GUARD_TICKS inside ptt at both ends.
- R5: A user drives tx_enable in at most one slot per sweep.
- R6: In user mode, when TIMEOUT_TICKS ticks pass with no query_det, the sweep is abandoned and ptt, tx_enable and slot_active fall at once. The next query starts a fresh sweep.
- R7: In hub mode, with the cycle counter c (0..REPEAT_TICKS-1) advancing one step per tick from 0 after hub mode is entered: query_req is a one-clock pulse after the tick with c = 0, and ptt and tx_enable are high after the ticks with c < QUERY_TICKS. The pattern repeats every REPEAT_TICKS ticks.
- R8: In hub mode, the slot sweep starts one clock after the tick that ends the query phase. From then on it runs as in R2, so after the tick with cycle count c the sweep position is c-QUERY_TICKS-1.
- R9: query_det has no effect in hub mode. In user mode, query_req is never raised.
- R10: Without ticks the sweep does not advance: slot_idx, ptt and tx_enable hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base enable, one pulse per tick |
| central_mode | input | 1 | 1 = hub, 0 = remote user |
| user_id | input | clog2(N_USERS) | Slot number assigned to this user |
| query_det | input | 1 | One-clock pulse at the end of a received query |
| data_pending | input | 1 | User has data to send this cycle |
| query_req | output | 1 | Hub: one-clock request to send a query frame |
| tx_enable | output | 1 | Modulated data (or query) may be sent |
| ptt | output | 1 | Radio push-to-talk keying |
| slot_active | output | 1 | A slot sweep is in progress |
| slot_idx | output | clog2(N_USERS) | Current slot number during a sweep |

## Verification
Two of the block's functions can act in the same clock. In that case the bench checks which one takes effect. A query_det pulse is driven while tick is high and while a sweep is already running. The re-anchored sweep must then start again at slot 0 position 0, and the tick in that clock must not be counted. A second instance with a short timeout sees its watchdog expire partway through a sweep, and the bench checks that the outputs drop on exactly the computed tick. In hub mode, query_det pulses are injected in clocks where the cycle counter wraps or the query phase ends, and the hub timeline must stay unchanged.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

  // counter width for values 0..n-1, never below one bit
  function automatic int cnt_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // data may flow at in-slot position pos when clear of both guards
  function automatic logic in_data_span(input int pos, input int slot_len,
                                        input int guard);
    return (pos >= guard) && (pos + guard < slot_len);
  endfunction

endpackage

// File: rtl/tdma_cycle_timer.sv
module tdma_cycle_timer #(
  parameter int QUERY_TICKS  = 200,
  parameter int REPEAT_TICKS = 3500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  output logic qphase,
  output logic qreq,
  output logic sweep_start
);
  localparam int CW = tdma_pkg::cnt_w(REPEAT_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          qph_q, qph_d;
  logic          req_q, req_d;
  logic          st_q, st_d;

  always_comb begin
    cnt_d = cnt_q;
    qph_d = qph_q;
    req_d = 1'b0;
    st_d  = 1'b0;
    if (!en) begin
      cnt_d = '0;
      qph_d = 1'b0;
    end else if (tick) begin
      cnt_d = (cnt_q == CW'(REPEAT_TICKS - 1)) ? '0 : cnt_q + CW'(1);
      if (cnt_q == '0) begin
        qph_d = 1'b1;
        req_d = 1'b1;
      end
      if (cnt_q == CW'(QUERY_TICKS)) begin
        qph_d = 1'b0;
        st_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      qph_q <= 1'b0;
      req_q <= 1'b0;
      st_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      qph_q <= qph_d;
      req_q <= req_d;
      st_q  <= st_d;
    end
  end

  assign qphase      = qph_q;
  assign qreq        = req_q;
  assign sweep_start = st_q;

  // R7: a query request always coincides with the start of the query phase
  a_r7_req_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> qph_q);
  // R8: the sweep is launched only right after a query phase closes
  a_r8_start_after_query: assert property (@(posedge clk) disable iff (!rst_n)
    st_q |-> (!qph_q && $past(qph_q)));

endmodule

// File: rtl/tdma_slot_seq.sv
module tdma_slot_seq #(
  parameter int N_SLOTS       = 3,
  parameter int SLOT_TICKS    = 1000,
  parameter int TIMEOUT_TICKS = 4000
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                tick,
  input  logic                                start,
  input  logic                                watch_en,
  output logic                                active,
  output logic [tdma_pkg::cnt_w(N_SLOTS)-1:0]    slot_no,
  output logic [tdma_pkg::cnt_w(SLOT_TICKS)-1:0] slot_pos
);
  localparam int SNW = tdma_pkg::cnt_w(N_SLOTS);
  localparam int SCW = tdma_pkg::cnt_w(SLOT_TICKS);
  localparam int TOW = tdma_pkg::cnt_w(TIMEOUT_TICKS + 1);

  logic           act_q, act_d;
  logic [SNW-1:0] no_q, no_d;
  logic [SCW-1:0] cnt_q, cnt_d;
  logic [TOW-1:0] to_q, to_d;
  logic           abort;

  always_comb begin
    act_d = act_q;
    no_d  = no_q;
    cnt_d = cnt_q;
    to_d  = to_q;
    abort = watch_en && !start && tick && (to_q == TOW'(TIMEOUT_TICKS - 1));
    if (!watch_en || start)
      to_d = '0;
    else if (tick && (to_q != TOW'(TIMEOUT_TICKS)))
      to_d = to_q + TOW'(1);
    if (start) begin
      act_d = 1'b1;
      no_d  = '0;
      cnt_d = '0;
    end else if (abort) begin
      act_d = 1'b0;
    end else if (act_q && tick) begin
      if (cnt_q == SCW'(SLOT_TICKS - 1)) begin
        cnt_d = '0;
        if (no_q == SNW'(N_SLOTS - 1)) act_d = 1'b0;
        else                            no_d  = no_q + SNW'(1);
      end else begin
        cnt_d = cnt_q + SCW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      no_q  <= '0;
      cnt_q <= '0;
      to_q  <= '0;
    end else begin
      act_q <= act_d;
      no_q  <= no_d;
      cnt_q <= cnt_d;
      to_q  <= to_d;
    end
  end

  assign active   = act_q;
  assign slot_no  = no_q;
  assign slot_pos = cnt_q;

  // R2: the slot number never leaves the user range during a sweep
  a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (no_q < SNW'(N_SLOTS)));
  // R6: an expired watchdog leaves the sweep idle on the next clock
  a_r6_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !act_q);
  // R10: with neither tick nor start the sweep position holds
  a_r10_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start) |=> ($stable(cnt_q) && $stable(no_q)));

endmodule

// File: rtl/tdma_tx_window.sv
module tdma_tx_window #(
  parameter int N_SLOTS     = 3,
  parameter int SLOT_TICKS  = 1000,
  parameter int GUARD_TICKS = 50
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   central,
  input  logic                                   qphase,
  input  logic                                   start,
  input  logic                                   data_pending,
  input  logic                                   active,
  input  logic [tdma_pkg::cnt_w(N_SLOTS)-1:0]    slot_no,
  input  logic [tdma_pkg::cnt_w(SLOT_TICKS)-1:0] slot_pos,
  input  logic [tdma_pkg::cnt_w(N_SLOTS)-1:0]    user_id,
  output logic                                   ptt,
  output logic                                   tx_enable
);
  logic pend_q, pend_d;
  logic own;

  always_comb begin
    pend_d = start ? data_pending : pend_q;
    own    = !central && active && pend_q && (slot_no == user_id);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_comb begin
    if (central) begin
      ptt       = qphase;
      tx_enable = qphase;
    end else begin
      ptt       = own;
      tx_enable = own && tdma_pkg::in_data_span(int'(slot_pos), SLOT_TICKS,
                                                GUARD_TICKS);
    end
  end

  // R4: data never flows with the radio unkeyed
  a_r4_tx_within_ptt: assert property (@(posedge clk) disable iff (!rst_n)
    tx_enable |-> ptt);
  // R3: a user keys only with data latched at the query
  a_r3_keyed_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!central && ptt) |-> pend_q);
  // R5: a running data window never moves to another slot
  a_r5_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!central && tx_enable && !start) |=> (!tx_enable || $stable(slot_no)));

endmodule

// File: rtl/tdma_slot_ctrl.sv
module tdma_slot_ctrl #(
  parameter int N_USERS       = 3,
  parameter int SLOT_TICKS    = 1000,
  parameter int GUARD_TICKS   = 50,
  parameter int QUERY_TICKS   = 200,
  parameter int REPEAT_TICKS  = 3500,
  parameter int TIMEOUT_TICKS = 4000,
  localparam int UIDW         = tdma_pkg::cnt_w(N_USERS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            central_mode,
  input  logic [UIDW-1:0] user_id,
  input  logic            query_det,
  input  logic            data_pending,
  output logic            query_req,
  output logic            tx_enable,
  output logic            ptt,
  output logic            slot_active,
  output logic [UIDW-1:0] slot_idx
);
  localparam int SCW = tdma_pkg::cnt_w(SLOT_TICKS);

  logic            qphase, qreq, hub_start, start;
  logic            active;
  logic [UIDW-1:0] slot_no;
  logic [SCW-1:0]  slot_pos;

  tdma_cycle_timer #(
    .QUERY_TICKS (QUERY_TICKS),
    .REPEAT_TICKS(REPEAT_TICKS)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (central_mode),
    .tick       (tick),
    .qphase     (qphase),
    .qreq       (qreq),
    .sweep_start(hub_start)
  );

  assign start = central_mode ? hub_start : query_det;

  tdma_slot_seq #(
    .N_SLOTS      (N_USERS),
    .SLOT_TICKS   (SLOT_TICKS),
    .TIMEOUT_TICKS(TIMEOUT_TICKS)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .start   (start),
    .watch_en(!central_mode),
    .active  (active),
    .slot_no (slot_no),
    .slot_pos(slot_pos)
  );

  tdma_tx_window #(
    .N_SLOTS    (N_USERS),
    .SLOT_TICKS (SLOT_TICKS),
    .GUARD_TICKS(GUARD_TICKS)
  ) u_win (
    .clk         (clk),
    .rst_n       (rst_n),
    .central     (central_mode),
    .qphase      (qphase),
    .start       (start),
    .data_pending(data_pending),
    .active      (active),
    .slot_no     (slot_no),
    .slot_pos    (slot_pos),
    .user_id     (user_id),
    .ptt         (ptt),
    .tx_enable   (tx_enable)
  );

  assign query_req   = qreq;
  assign slot_active = active;
  assign slot_idx    = slot_no;

  // R9: a remote user never asks for a query frame
  a_r9_no_req_user: assert property (@(posedge clk) disable iff (!rst_n)
    !central_mode |=> !query_req);
  // R7: the hub keys the radio whenever it requests a query
  a_r7_req_keys: assert property (@(posedge clk) disable iff (!rst_n)
    (central_mode && query_req) |-> (ptt && tx_enable));

endmodule

// File: tb/tdma_slot_ctrl_test.sv
`timescale 1ns/1ps
module tdma_slot_ctrl_test;
  localparam int N  = 3;
  localparam int S  = 8;
  localparam int G  = 2;
  localparam int Q  = 4;
  localparam int R  = 32;
  localparam int TO = 12;
  localparam int NS = N * S;

  logic clk = 1'b0;
  logic rst_n, tick, central, qdet, pend;
  logic [1:0] uid;
  logic a_qr, a_tx, a_pt, a_act; logic [1:0] a_idx;
  logic b_qr, b_tx, b_pt, b_act; logic [1:0] b_idx;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tdma_slot_ctrl #(.N_USERS(N), .SLOT_TICKS(S), .GUARD_TICKS(G), .QUERY_TICKS(Q),
    .REPEAT_TICKS(R), .TIMEOUT_TICKS(64)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .central_mode(central), .user_id(uid),
    .query_det(qdet), .data_pending(pend), .query_req(a_qr), .tx_enable(a_tx),
    .ptt(a_pt), .slot_active(a_act), .slot_idx(a_idx));

  tdma_slot_ctrl #(.N_USERS(N), .SLOT_TICKS(S), .GUARD_TICKS(G), .QUERY_TICKS(Q),
    .REPEAT_TICKS(R), .TIMEOUT_TICKS(TO)) uut_to (
    .clk(clk), .rst_n(rst_n), .tick(tick), .central_mode(central), .user_id(uid),
    .query_det(qdet), .data_pending(pend), .query_req(b_qr), .tx_enable(b_tx),
    .ptt(b_pt), .slot_active(b_act), .slot_idx(b_idx));

  task automatic cmp(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected user-mode outputs at tick position j; lim = ticks before idle
  task automatic chk_user(input string who, input int j, input int lim, input int u,
                          input bit p, input logic act, input logic [1:0] idx,
                          input logic pt, input logic tx, input logic qr);
    bit   e_act;
    bit   e_pt;
    bit   e_tx;
    string tg;
    e_act = (j < lim);
    e_pt  = e_act && p && (j / S == u);
    e_tx  = e_pt && ((j % S) >= G) && ((j % S) < S - G);
    tg    = (lim < NS && j >= lim) ? "R6" : "";
    cmp({who, " R2 active ", tg}, act, e_act);
    if (e_act) cmp({who, " R2 slot_idx"}, idx, j / S);
    cmp({who, " R3 ptt ", tg}, pt, e_pt);
    cmp({who, " R4 tx_enable ", tg}, tx, e_tx);
    cmp({who, " R9 query_req in user mode"}, qr, 0);
  endtask

  // query pulse, then sample positions 0..last_j
  task automatic run_frame(input int u, input bit p, input int last_j,
                           input bit flip_pend, input bit full);
    int a_cnt = 0;
    int b_cnt = 0;
    int a_last = -1;
    int b_last = -1;
    @(negedge clk);
    uid = 2'(u); pend = p; qdet = 1'b1;
    for (int j = 0; j <= last_j; j++) begin
      @(negedge clk);
      qdet = 1'b0;
      if (flip_pend) pend = ~p;
      chk_user("main", j, NS, u, p, a_act, a_idx, a_pt, a_tx, a_qr);
      chk_user("to", j, TO, u, p, b_act, b_idx, b_pt, b_tx, b_qr);
      if (a_tx && int'(a_idx) != a_last) begin a_cnt++; a_last = int'(a_idx); end
      if (b_tx && int'(b_idx) != b_last) begin b_cnt++; b_last = int'(b_idx); end
    end
    if (full) begin
      cmp("main R5 slots with tx per sweep", a_cnt, (p && u < N) ? 1 : 0);
      cmp("to R5 R6 slots with tx per sweep", b_cnt, (p && u < N && u * S + G < TO) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b1; central = 1'b0; qdet = 1'b0; pend = 1'b0; uid = '0;
    repeat (3) @(negedge clk);
    cmp("R1 reset tx_enable", a_tx, 0);
    cmp("R1 reset ptt", a_pt, 0);
    cmp("R1 reset query_req", a_qr, 0);
    cmp("R1 reset slot_active", a_act, 0);
    cmp("R1 reset slot_idx", a_idx, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (20) @(negedge clk);
    cmp("R1 idle ptt", a_pt | b_pt, 0);
    cmp("R1 idle active", a_act | b_act, 0);
    cmp("R1 idle tx_enable", a_tx | b_tx, 0);

    // sweep every user id including an out-of-range one, with and without data
    for (int u = 0; u < 4; u++)
      for (int p = 0; p < 2; p++) begin
        run_frame(u, p[0], NS + 3, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
      end

    // R3: data_pending changes after the query are ignored
    run_frame(1, 1'b1, NS + 3, 1'b1, 1'b1);
    run_frame(2, 1'b0, NS + 3, 1'b1, 1'b1);

    // R2: query during a running sweep re-anchors it (query and tick coincide)
    run_frame(0, 1'b1, 10, 1'b0, 1'b0);
    run_frame(2, 1'b1, NS + 3, 1'b0, 1'b1);
    run_frame(1, 1'b1, 13, 1'b0, 1'b0);
    run_frame(1, 1'b1, NS + 3, 1'b0, 1'b1);

    // R10: no ticks, no progress
    @(negedge clk); tick = 1'b0; uid = 2'd0; pend = 1'b1; qdet = 1'b1;
    @(negedge clk); qdet = 1'b0;
    repeat (30) @(negedge clk);
    cmp("R10 active held", a_act, 1);
    cmp("R10 slot_idx held", a_idx, 0);
    cmp("R10 ptt held", a_pt, 1);
    cmp("R10 tx_enable still in guard", a_tx, 0);
    cmp("R10 R6 no timeout without ticks", b_act, 1);
    tick = 1'b1;
    repeat (NS + 4) @(negedge clk);
    cmp("R2 sweep ended", a_act | b_act, 0);

    // hub mode; query_det pulses must be ignored
    @(negedge clk); central = 1'b1; pend = 1'b1;
    for (int k = 1; k <= 2 * R + 6; k++) begin
      int  c;
      int  ps;
      bit  e_act;
      @(negedge clk);
      c = (k - 1) % R;
      ps = c - Q - 1;
      e_act = (ps >= 0) && (ps < NS);
      cmp("R7 hub ptt", a_pt, c < Q);
      cmp("R7 hub tx_enable", a_tx, c < Q);
      cmp("R7 hub query_req", a_qr, c == 0);
      cmp("R8 hub sweep active", a_act, e_act);
      if (e_act) cmp("R8 hub slot_idx", a_idx, ps / S);
      cmp("R9 hub ignores query_det (second instance)", {b_pt, b_qr, b_act},
          {a_pt, a_qr, a_act});
      qdet = (c == R - 1) || (c == Q) || (k % 5 == 0);
    end
    @(negedge clk); qdet = 1'b0; central = 1'b0;
    @(negedge clk);
    cmp("R9 user mode no query_req", a_qr, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule